// File: doc/BRIEF.md
# Fused Multiply-Add NaN Result Selector

This unit decides which NaN a single-precision fused multiply-add (a*b)+c returns once the arithmetic datapath has found a NaN among its inputs. It takes the three operand words and an indication that the product was zero times infinity. It returns four things: a 2-bit pick code, the final result word, an invalid-operation flag, and a valid strobe. The strobe is registered and follows the input strobe by one cycle.

Each operand is classified as quiet NaN, signaling NaN or neither. A runtime policy input selects one of four priority schemes. Each scheme has its own treatment of the zero-times-infinity case. A signaling NaN that is chosen is quietened before it is returned. A default-NaN mode forces the result word to the canonical NaN. This override acts only after the pick is made, so the pick code and the invalid flag still reflect the operands.

Top module: `fma_nan_sel`

## Requirements
- R1: An operand is a quiet NaN when bits 30:23 are all ones and bit 22 is 1. It is a signaling NaN when bits 30:23 are all ones, bit 22 is 0 and bits 21:0 are non-zero. Every other word is not a NaN.
- R2: The pick code sel_o is 0 for a, 1 for b, 2 for c and 3 for the default NaN. When the code is 3, result_o is 0x7FC00000.
- R3: Policy 0: if infzero is set and c is a quiet NaN, the pick is 3. Otherwise the first match wins in this order: c signaling, a signaling, b signaling, c quiet, a quiet, else b.
- R4: Policy 1: if infzero is set, the pick is 3. Otherwise the first match wins in this order: a signaling, b signaling, c signaling, a quiet, b quiet, else c.
- R5: Policy 2: if infzero is set, the pick is c. Otherwise the pick is a if a is any NaN, then c if c is any NaN, else b.
- R6: Policy 3: the pick is a if a is any NaN, then b if b is any NaN, else c. The infzero input has no effect on the pick or on the invalid flag.
- R7: invalid_o is set when any operand is a signaling NaN. It is also set when infzero applies: under policy 0 only if c is a quiet NaN, and under policies 1 and 2 always.
- R8: When an operand is picked, result_o is that operand with bit 22 forced to 1 if the operand is a signaling NaN. All other bits, including the sign, are unchanged.
- R9: When dnan_mode_i is set, result_o is 0x7FC00000. sel_o and invalid_o keep the values they would have without the mode.
- R10: Outputs appear one clock after a cycle with valid_i high, and valid_o is high for exactly that cycle. While valid_i is low, sel_o, result_o and invalid_o hold their values.
- R11: During and after reset, valid_o, sel_o, result_o and invalid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands and controls are valid |
| a_i | input | 32 | Multiplicand operand |
| b_i | input | 32 | Multiplier operand |
| c_i | input | 32 | Addend operand |
| infzero_i | input | 1 | Product was zero times infinity |
| policy_i | input | 2 | Priority scheme select, 0 to 3 |
| dnan_mode_i | input | 1 | Force the result to the default NaN |
| valid_o | output | 1 | Registered outputs updated |
| sel_o | output | 2 | Pick code: a, b, c or default |
| result_o | output | 32 | Final NaN result word |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
A fault in classification or in the priority logic appears at sel_o on the cycle after the first operand combination that exercises it. A fault in the silencing path or the default override corrupts result_o on that same cycle. The bench sweeps every mix of ordinary number, infinity, quiet NaN and signaling NaN across the three operands. It runs that sweep under each policy, with infzero on and off and with the default mode on and off. This exposes a mis-ordered priority or a missing invalid term within one registered cycle of the vector that reaches it. A broken capture enable shows up as outputs that move while valid_i is low.

// File: rtl/fma_nan_pkg.sv
package fma_nan_pkg;

  typedef enum logic [1:0] {
    PICK_A    = 2'd0,
    PICK_B    = 2'd1,
    PICK_C    = 2'd2,
    PICK_DFLT = 2'd3
  } pick_e;

  typedef enum logic [1:0] {
    POL_CFIRST = 2'd0,
    POL_SNAN_ABC = 2'd1,
    POL_ACB    = 2'd2,
    POL_ABC    = 2'd3
  } policy_e;

  typedef struct packed {
    logic qnan;
    logic snan;
  } nan_cls_t;

  localparam int unsigned NUM_OPS = 3;

endpackage

// File: rtl/fma_nan_classify.sv
module fma_nan_classify
  import fma_nan_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  output nan_cls_t          cls_o
);

  logic exp_max;
  logic quiet_bit;
  logic low_payload;

  assign exp_max     = &op_i[WORD_W-2:FRAC_W];
  assign quiet_bit   = op_i[FRAC_W-1];
  assign low_payload = |op_i[FRAC_W-2:0];

  always_comb begin
    cls_o.qnan = exp_max & quiet_bit;
    cls_o.snan = exp_max & ~quiet_bit & low_payload;
  end

endmodule

// File: rtl/fma_nan_prio.sv
module fma_nan_prio
  import fma_nan_pkg::*;
(
  input  nan_cls_t   a_cls_i,
  input  nan_cls_t   b_cls_i,
  input  nan_cls_t   c_cls_i,
  input  logic       infzero_i,
  input  logic [1:0] policy_i,
  output pick_e      pick_o,
  output logic       iz_invalid_o
);

  logic a_any, b_any, c_any;

  assign a_any = a_cls_i.qnan | a_cls_i.snan;
  assign b_any = b_cls_i.qnan | b_cls_i.snan;
  assign c_any = c_cls_i.qnan | c_cls_i.snan;

  always_comb begin
    pick_o       = PICK_B;
    iz_invalid_o = 1'b0;
    unique case (policy_e'(policy_i))
      POL_CFIRST: begin
        if (infzero_i && c_cls_i.qnan) begin
          iz_invalid_o = 1'b1;
          pick_o       = PICK_DFLT;
        end else if (c_cls_i.snan) pick_o = PICK_C;
        else if (a_cls_i.snan)     pick_o = PICK_A;
        else if (b_cls_i.snan)     pick_o = PICK_B;
        else if (c_cls_i.qnan)     pick_o = PICK_C;
        else if (a_cls_i.qnan)     pick_o = PICK_A;
        else                       pick_o = PICK_B;
      end
      POL_SNAN_ABC: begin
        if (infzero_i) begin
          iz_invalid_o = 1'b1;
          pick_o       = PICK_DFLT;
        end else if (a_cls_i.snan) pick_o = PICK_A;
        else if (b_cls_i.snan)     pick_o = PICK_B;
        else if (c_cls_i.snan)     pick_o = PICK_C;
        else if (a_cls_i.qnan)     pick_o = PICK_A;
        else if (b_cls_i.qnan)     pick_o = PICK_B;
        else                       pick_o = PICK_C;
      end
      POL_ACB: begin
        if (infzero_i) begin
          iz_invalid_o = 1'b1;
          pick_o       = PICK_C;
        end else if (a_any) pick_o = PICK_A;
        else if (c_any)     pick_o = PICK_C;
        else                pick_o = PICK_B;
      end
      default: begin
        if (a_any)      pick_o = PICK_A;
        else if (b_any) pick_o = PICK_B;
        else            pick_o = PICK_C;
      end
    endcase
  end

endmodule

// File: rtl/fma_nan_quiet.sv
module fma_nan_quiet
  import fma_nan_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] op_i,
  input  nan_cls_t          cls_i,
  output logic [WORD_W-1:0] op_o
);

  localparam logic [WORD_W-1:0] QUIET_MASK = WORD_W'(1) << (FRAC_W - 1);

  assign op_o = cls_i.snan ? (op_i | QUIET_MASK) : op_i;

endmodule

// File: rtl/fma_nan_sel.sv
module fma_nan_sel
  import fma_nan_pkg::*;
#(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  logic [WORD_W-1:0] c_i,
  input  logic              infzero_i,
  input  logic [1:0]        policy_i,
  input  logic              dnan_mode_i,
  output logic              valid_o,
  output logic [1:0]        sel_o,
  output logic [WORD_W-1:0] result_o,
  output logic              invalid_o
);

  localparam logic [WORD_W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [WORD_W-1:0] ops       [NUM_OPS];
  logic [WORD_W-1:0] quiet_ops [NUM_OPS];
  nan_cls_t          cls       [NUM_OPS];

  assign ops[0] = a_i;
  assign ops[1] = b_i;
  assign ops[2] = c_i;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    fma_nan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op_i  (ops[i]),
      .cls_o (cls[i])
    );
    fma_nan_quiet #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_quiet (
      .op_i  (ops[i]),
      .cls_i (cls[i]),
      .op_o  (quiet_ops[i])
    );
  end

  pick_e pick;
  logic  iz_invalid;

  fma_nan_prio u_prio (
    .a_cls_i      (cls[0]),
    .b_cls_i      (cls[1]),
    .c_cls_i      (cls[2]),
    .infzero_i    (infzero_i),
    .policy_i     (policy_i),
    .pick_o       (pick),
    .iz_invalid_o (iz_invalid)
  );

  logic [WORD_W-1:0] result_d;
  logic              invalid_d;

  // default-mode override sits after the pick so flags still reflect operands
  always_comb begin
    unique case (pick)
      PICK_A:  result_d = quiet_ops[0];
      PICK_B:  result_d = quiet_ops[1];
      PICK_C:  result_d = quiet_ops[2];
      default: result_d = DEFAULT_NAN;
    endcase
    if (dnan_mode_i) result_d = DEFAULT_NAN;
    invalid_d = cls[0].snan | cls[1].snan | cls[2].snan | iz_invalid;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sel_o     <= 2'd0;
      result_o  <= '0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sel_o     <= pick;
        result_o  <= result_d;
        invalid_o <= invalid_d;
      end
    end
  end

endmodule

// File: rtl/fma_nan_sel_chk.sv
module fma_nan_sel_chk #(
  parameter int unsigned EXP_W  = 8,
  parameter int unsigned FRAC_W = 23,
  localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic [WORD_W-1:0] c_i,
  input logic              infzero_i,
  input logic [1:0]        policy_i,
  input logic              dnan_mode_i,
  input logic              valid_o,
  input logic [1:0]        sel_o,
  input logic [WORD_W-1:0] result_o,
  input logic              invalid_o
);

  localparam logic [WORD_W-1:0] DFLT =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  function automatic logic sig_nan(input logic [WORD_W-1:0] w);
    return (&w[WORD_W-2:FRAC_W]) && !w[FRAC_W-1] && (|w[FRAC_W-2:0]);
  endfunction

  logic any_snan;
  assign any_snan = sig_nan(a_i) | sig_nan(b_i) | sig_nan(c_i);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o) else $error("valid_o missing");  // R10
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(sel_o) && $stable(result_o) && $stable(invalid_o))
    else $error("outputs moved while idle");  // R10
  AST_SNAN_INVALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && any_snan |=> invalid_o) else $error("invalid not raised");  // R7
  AST_DNAN_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && dnan_mode_i |=> result_o == DFLT) else $error("default not forced");  // R9
  AST_NO_SNAN_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !sig_nan(result_o)) else $error("signaling NaN escaped");  // R8
  AST_P1_INFZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && policy_i == 2'd1 && infzero_i |=> sel_o == 2'd3 && invalid_o)
    else $error("policy 1 infzero");  // R4
  AST_P2_INFZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && policy_i == 2'd2 && infzero_i |=> sel_o == 2'd2 && invalid_o)
    else $error("policy 2 infzero");  // R5
  AST_DFLT_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && sel_o == 2'd3 |-> result_o == DFLT) else $error("default word");  // R2

endmodule

bind fma_nan_sel fma_nan_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (.*);

// File: tb/fma_nan_sel_tb.sv
`timescale 1ns/1ps
module fma_nan_sel_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0, c_i = '0;
  logic        infzero_i = 1'b0;
  logic [1:0]  policy_i = 2'd0;
  logic        dnan_mode_i = 1'b0;
  logic        valid_o;
  logic [1:0]  sel_o;
  logic [31:0] result_o;
  logic        invalid_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk_i = ~clk_i;

  fma_nan_sel u_dut (.*);

  localparam logic [31:0] DNAN = 32'h7FC0_0000;

  function automatic bit is_q(input logic [31:0] w);
    return w[30:23] == 8'hFF && w[22];
  endfunction
  function automatic bit is_s(input logic [31:0] w);
    return w[30:23] == 8'hFF && !w[22] && w[21:0] != 0;
  endfunction

  // kind 0 number, 1 quiet NaN, 2 signaling NaN, 3 infinity
  function automatic logic [31:0] mk(input int kind, input logic [7:0] id, input bit neg);
    logic [31:0] w;
    case (kind)
      0:       w = 32'h3F80_0000 | 32'(id);
      1:       w = 32'h7FC0_0000 | 32'(id);
      2:       w = 32'h7F80_0000 | 32'(id);
      default: w = 32'h7F80_0000;
    endcase
    if (neg) w[31] = 1'b1;
    return w;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_model(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                           input bit iz, input int pol, input bit dn,
                           output logic [1:0] sel, output logic [31:0] res, output bit inv);
    bit aq, as_, bq, bs, cq, cs, izinv;
    logic [31:0] pickw;
    aq = is_q(a); as_ = is_s(a); bq = is_q(b); bs = is_s(b); cq = is_q(c); cs = is_s(c);
    izinv = 1'b0;
    case (pol)
      0: begin  // R3
        if (iz && cq) begin sel = 2'd3; izinv = 1'b1; end
        else if (cs) sel = 2'd2; else if (as_) sel = 2'd0; else if (bs) sel = 2'd1;
        else if (cq) sel = 2'd2; else if (aq) sel = 2'd0; else sel = 2'd1;
      end
      1: begin  // R4
        if (iz) begin sel = 2'd3; izinv = 1'b1; end
        else if (as_) sel = 2'd0; else if (bs) sel = 2'd1; else if (cs) sel = 2'd2;
        else if (aq) sel = 2'd0; else if (bq) sel = 2'd1; else sel = 2'd2;
      end
      2: begin  // R5
        if (iz) begin sel = 2'd2; izinv = 1'b1; end
        else if (aq || as_) sel = 2'd0; else if (cq || cs) sel = 2'd2; else sel = 2'd1;
      end
      default: begin  // R6
        if (aq || as_) sel = 2'd0; else if (bq || bs) sel = 2'd1; else sel = 2'd2;
      end
    endcase
    inv = as_ | bs | cs | izinv;
    case (sel)
      2'd0: pickw = a;
      2'd1: pickw = b;
      2'd2: pickw = c;
      default: pickw = DNAN;
    endcase
    if (sel != 2'd3 && is_s(pickw)) pickw[22] = 1'b1;
    res = dn ? DNAN : pickw;
  endtask

  initial begin
    #(5.0 * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [1:0]  esel;
    logic [31:0] eres;
    bit          einv;
    string       ptag;
    logic [1:0]  hsel;
    logic [31:0] hres;
    logic        hinv;

    repeat (3) @(negedge clk_i);
    check("R11 valid_o", 32'(valid_o), 32'd0);
    check("R11 sel_o", 32'(sel_o), 32'd0);
    check("R11 result_o", result_o, 32'd0);
    check("R11 invalid_o", 32'(invalid_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R11 valid_o after release", 32'(valid_o), 32'd0);

    for (int pol = 0; pol < 4; pol++) begin
      for (int iz = 0; iz < 2; iz++) begin
        for (int dn = 0; dn < 2; dn++) begin
          for (int ka = 0; ka < 4; ka++) begin
            for (int kb = 0; kb < 4; kb++) begin
              for (int kc = 0; kc < 4; kc++) begin
                a_i = mk(ka, 8'h11, 1'b0);
                b_i = mk(kb, 8'h22, 1'b1);
                c_i = mk(kc, 8'h33, 1'b0);
                infzero_i   = iz[0];
                policy_i    = pol[1:0];
                dnan_mode_i = dn[0];
                valid_i     = 1'b1;
                ref_model(a_i, b_i, c_i, iz[0], pol, dn[0], esel, eres, einv);
                @(negedge clk_i);
                case (pol)
                  0: ptag = "R3 R2 sel";
                  1: ptag = "R4 R2 sel";
                  2: ptag = "R5 R2 sel";
                  default: ptag = "R6 R2 sel";
                endcase
                check("R10 valid_o", 32'(valid_o), 32'd1);
                check(ptag, 32'(sel_o), 32'(esel));
                check(dn != 0 ? "R9 result" : "R8 R1 result", result_o, eres);
                check("R7 invalid", 32'(invalid_o), 32'(einv));
              end
            end
          end
        end
      end
    end

    hsel = sel_o; hres = result_o; hinv = invalid_o;
    valid_i = 1'b0;
    a_i = 32'h7F80_0001; b_i = 32'h7F80_0002; c_i = 32'h7F80_0003;
    policy_i = 2'd1; infzero_i = 1'b1; dnan_mode_i = 1'b0;
    @(negedge clk_i);
    check("R10 idle valid_o", 32'(valid_o), 32'd0);
    check("R10 idle sel hold", 32'(sel_o), 32'(hsel));
    check("R10 idle result hold", result_o, hres);
    check("R10 idle invalid hold", 32'(invalid_o), 32'(hinv));
    @(negedge clk_i);
    check("R10 idle second cycle", result_o, hres);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule